// File: doc/BRIEF.md
# Output Level Controller with Soft Mute and Silence Detect

This block sits in a stereo sample path ahead of the filter and modulator stages. It scales each signed left and right sample by a linear gain. The gain is the product of a 7-bit attenuation code and a soft-mute level. The attenuation code is a static setting. The soft-mute level moves in fixed steps, paced by a millisecond tick. It falls to silence when mute is requested and climbs back to full scale when the request is withdrawn.

A separate timer watches the incoming samples. It raises a silence flag once both channels have carried only zero samples for a long, parameterised run of milliseconds. Any nonzero sample drops the flag and restarts the run.

Each channel has its own valid strobe. A scaled sample leaves the block one clock after it enters, together with an output strobe.

Top module: `out_level_ctrl`

## Requirements
- R1: With attenuation code 127 and the mute level at full scale, an input sample leaves the block unchanged, including -32768 and 32767.
- R2: Attenuation code 0 yields an output of exactly 0 for any input sample.
- R3: For codes 1 to 126, the output equals sample*code/127, rounded toward zero (for example 32767 at code 122 gives 31476, and -32768 at code 122 gives -31477).
- R4: A sample accepted on a valid strobe appears on the output one clock later, with its output strobe high for that one clock. Without a strobe, the output strobe stays low and the output value holds.
- R5: After the mute request rises, each of the next 20 millisecond ticks lowers the level. After t ticks the level is 64 - floor(64*t/20), and the output is sample*level/64 rounded toward zero. The output is therefore 0 after the 20th tick and not before.
- R6: After the mute request falls from a silent state, the level after t ticks is floor(64*t/20), and it reaches full scale on the 20th tick.
- R7: A change of the mute request while a ramp is in progress does not alter that ramp's direction or its length.
- R8: When a ramp completes, the request level is taken again. If the request disagrees with the completed direction, the opposite ramp starts without any new edge on the request.
- R9: The silence flag rises after both channels have received a zero sample and then 350 consecutive millisecond ticks pass with no nonzero sample on either channel. After 349 such ticks the flag is still low.
- R10: A nonzero sample on either channel lowers the silence flag on the next clock and restarts the 350-tick run.
- R11: After reset, both outputs are 0, the output strobes are low, the silence flag is low, and the mute level is at full scale.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| l_vld | input | 1 | Left sample strobe |
| l_smp | input | 16 | Left sample, two's complement |
| r_vld | input | 1 | Right sample strobe |
| r_smp | input | 16 | Right sample, two's complement |
| att_code | input | 7 | Linear gain code, gain = code/127 |
| mute_req | input | 1 | Soft mute request level |
| ms_tick | input | 1 | One-clock pulse every millisecond |
| l_out | output | 16 | Scaled left sample |
| l_out_vld | output | 1 | Left output strobe |
| r_out | output | 16 | Scaled right sample |
| r_out_vld | output | 1 | Right output strobe |
| silence | output | 1 | Both channels silent for the full run |

## Verification
The assertions assume a few things about the inputs. The millisecond tick is a single-clock pulse. Every sample that counts arrives on its strobe. A tick and a ramp start may fall in the same clock, and the step bound still holds in that case. The stimulus changes the attenuation code only between samples. It drives ticks as isolated one-clock pulses with idle clocks between them. It changes the mute request only on clocks without a tick, so each expected level is a plain function of the ticks counted since the ramp started.

// File: rtl/oc_pkg.sv
// Shared types for the output level controller.
package oc_pkg;
    // Soft-mute sequencer states
    typedef enum logic [1:0] {
        RMP_FULL   = 2'd0,
        RMP_DOWN   = 2'd1,
        RMP_SILENT = 2'd2,
        RMP_UP     = 2'd3
    } ramp_state_t;
endpackage

// File: rtl/oc_gain_chan.sv
// One channel's gain stage: out = sample * code * level / (CODE_MAX * STEPS),
// truncated toward zero and registered. Assumes level <= STEPS and code <= CODE_MAX,
// so the quotient always fits back into DW bits.
module oc_gain_chan #(
    parameter int DW    = 16,
    parameter int AW    = 7,
    parameter int STEPS = 64,
    parameter int LW    = $clog2(STEPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic signed [DW-1:0] in_smp,
    input  logic [AW-1:0]        att,
    input  logic [LW-1:0]        lvl,
    output logic                 out_vld,
    output logic signed [DW-1:0] out_smp
);
    localparam int CODE_MAX = (1 << AW) - 1;
    localparam int PW       = DW + AW + LW + 2;
    localparam logic signed [PW-1:0] DEN = PW'(CODE_MAX * STEPS);

    logic signed [PW-1:0] s_x, a_x, l_x, prod, quot;

    // Widen operands and form the truncating quotient
    always_comb begin
        s_x  = PW'(in_smp);
        a_x  = PW'({1'b0, att});
        l_x  = PW'({1'b0, lvl});
        prod = s_x * a_x * l_x;
        quot = prod / DEN;
    end

    // Register the scaled sample and its strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld <= 1'b0;
            out_smp <= '0;
        end else begin
            out_vld <= in_vld;
            if (in_vld) out_smp <= quot[DW-1:0];
        end
    end
endmodule

// File: rtl/oc_mute_ramp.sv
// Soft-mute level sequencer. The level runs 0..STEPS. On each ms tick during a
// ramp, a fractional accumulator adds STEPS/RAMP_MS steps, so a ramp takes
// exactly RAMP_MS ticks. The request is looked at only while idle, which means
// changes during a ramp are ignored and a stale request is re-taken at the end.
// Assumes the tick is a one-clock pulse.
module oc_mute_ramp
    import oc_pkg::*;
#(
    parameter int STEPS   = 64,
    parameter int RAMP_MS = 20,
    parameter int LW      = $clog2(STEPS + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mute_req,
    input  logic          ms_tick,
    output logic [LW-1:0] lvl
);
    localparam int AccW = $clog2(STEPS + RAMP_MS + 1);

    ramp_state_t      st;
    logic [AccW-1:0]  acc, sum, adv, rem;
    logic [LW-1:0]    adv_l;

    // Steps earned by this tick and the carried remainder
    always_comb begin
        sum   = acc + AccW'(STEPS);
        adv   = sum / AccW'(RAMP_MS);
        rem   = sum % AccW'(RAMP_MS);
        adv_l = LW'(adv);
    end

    // Sequencer and level register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st  <= RMP_FULL;
            lvl <= LW'(STEPS);
            acc <= '0;
        end else begin
            unique case (st)
                RMP_FULL: begin
                    if (mute_req) begin
                        st  <= RMP_DOWN;
                        acc <= '0;
                    end
                end
                RMP_SILENT: begin
                    if (!mute_req) begin
                        st  <= RMP_UP;
                        acc <= '0;
                    end
                end
                RMP_DOWN: begin
                    if (ms_tick) begin
                        if (lvl <= adv_l) begin
                            lvl <= '0;
                            acc <= '0;
                            st  <= RMP_SILENT;
                        end else begin
                            lvl <= lvl - adv_l;
                            acc <= rem;
                        end
                    end
                end
                RMP_UP: begin
                    if (ms_tick) begin
                        if (lvl + adv_l >= LW'(STEPS)) begin
                            lvl <= LW'(STEPS);
                            acc <= '0;
                            st  <= RMP_FULL;
                        end else begin
                            lvl <= lvl + adv_l;
                            acc <= rem;
                        end
                    end
                end
                default: st <= RMP_FULL;
            endcase
        end
    end
endmodule

// File: rtl/oc_zero_timer.sv
// Silence detector. It remembers whether each channel's last sample was zero.
// While both were zero, it counts ms ticks up to ZERO_MS. A nonzero sample on
// either channel clears the count at once. Before the first zero sample, a
// channel counts as not silent.
module oc_zero_timer #(
    parameter int DW      = 16,
    parameter int NCH     = 2,
    parameter int ZERO_MS = 350
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      ch_vld,
    input  logic [NCH-1:0][DW-1:0] ch_smp,
    input  logic                ms_tick,
    output logic                silent
);
    localparam int CW = $clog2(ZERO_MS + 1);

    logic [NCH-1:0] ch_zero;
    logic [NCH-1:0] ch_hit;
    logic [CW-1:0]  cnt;

    // Per-channel nonzero arrival and zero memory
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        assign ch_hit[c] = ch_vld[c] && (ch_smp[c] != '0);
        always_ff @(posedge clk) begin
            if (!rst_n)         ch_zero[c] <= 1'b0;
            else if (ch_vld[c]) ch_zero[c] <= (ch_smp[c] == '0);
        end
    end

    // Run-length counter of silent milliseconds
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt <= '0;
        else if (|ch_hit)                 cnt <= '0;
        else if (ms_tick && (&ch_zero) && cnt < CW'(ZERO_MS))
                                          cnt <= cnt + 1'b1;
    end

    assign silent = (cnt == CW'(ZERO_MS));
endmodule

// File: rtl/out_level_ctrl.sv
// Output level controller top. It scales both channels by att_code/127 times the
// soft-mute level/64 and flags long silence. Assumes ms_tick is a one-clock
// pulse, and that att_code is held steady around each sample strobe.
module out_level_ctrl #(
    parameter int DW      = 16,
    parameter int AW      = 7,
    parameter int STEPS   = 64,
    parameter int RAMP_MS = 20,
    parameter int ZERO_MS = 350
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 l_vld,
    input  logic signed [DW-1:0] l_smp,
    input  logic                 r_vld,
    input  logic signed [DW-1:0] r_smp,
    input  logic [AW-1:0]        att_code,
    input  logic                 mute_req,
    input  logic                 ms_tick,
    output logic signed [DW-1:0] l_out,
    output logic                 l_out_vld,
    output logic signed [DW-1:0] r_out,
    output logic                 r_out_vld,
    output logic                 silence
);
    localparam int NCH = 2;
    localparam int LW  = $clog2(STEPS + 1);

    logic [LW-1:0]             mute_lvl;
    logic [NCH-1:0]            in_vld, o_vld;
    logic [NCH-1:0][DW-1:0]    in_smp, o_smp;

    assign in_vld = {r_vld, l_vld};
    assign in_smp = {r_smp, l_smp};

    oc_mute_ramp #(.STEPS(STEPS), .RAMP_MS(RAMP_MS), .LW(LW)) u_ramp (
        .clk(clk), .rst_n(rst_n), .mute_req(mute_req), .ms_tick(ms_tick), .lvl(mute_lvl)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_gain
        oc_gain_chan #(.DW(DW), .AW(AW), .STEPS(STEPS), .LW(LW)) u_gain (
            .clk(clk), .rst_n(rst_n), .in_vld(in_vld[c]), .in_smp(in_smp[c]),
            .att(att_code), .lvl(mute_lvl), .out_vld(o_vld[c]), .out_smp(o_smp[c])
        );
    end

    oc_zero_timer #(.DW(DW), .NCH(NCH), .ZERO_MS(ZERO_MS)) u_zero (
        .clk(clk), .rst_n(rst_n), .ch_vld(in_vld), .ch_smp(in_smp),
        .ms_tick(ms_tick), .silent(silence)
    );

    assign l_out     = o_smp[0];
    assign r_out     = o_smp[1];
    assign l_out_vld = o_vld[0];
    assign r_out_vld = o_vld[1];
endmodule

// File: rtl/oc_level_chk.sv
// Property checker for out_level_ctrl, attached by bind below.
module oc_level_chk #(
    parameter int DW      = 16,
    parameter int AW      = 7,
    parameter int STEPS   = 64,
    parameter int RAMP_MS = 20,
    parameter int LW      = $clog2(STEPS + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 l_vld,
    input logic signed [DW-1:0] l_smp,
    input logic                 r_vld,
    input logic signed [DW-1:0] r_smp,
    input logic [AW-1:0]        att_code,
    input logic                 ms_tick,
    input logic signed [DW-1:0] l_out,
    input logic                 l_out_vld,
    input logic                 silence,
    input logic [LW-1:0]        mute_lvl
);
    localparam int MAXSTEP = (STEPS + RAMP_MS - 1) / RAMP_MS;

    function automatic logic [DW:0] mag(input logic signed [DW-1:0] v);
        logic signed [DW:0] w;
        w = DW'(v) == 0 ? '0 : {v[DW-1], v};
        return (w < 0) ? DW'(0) - w : w;
    endfunction

    // R1: full code at full level passes the sample unchanged
    assert_unity_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (l_vld && att_code == AW'((1 << AW) - 1) && mute_lvl == LW'(STEPS)) |=> (l_out == $past(l_smp)));

    // R2: code zero silences the channel
    assert_code_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (l_vld && att_code == '0) |=> (l_out == '0));

    // R3: the gain never raises the magnitude
    assert_no_gain_R3: assert property (@(posedge clk) disable iff (!rst_n)
        l_vld |=> (mag(l_out) <= mag($past(l_smp))));

    // R4: output strobe follows input strobe by one clock
    assert_strobe_lat_R4: assert property (@(posedge clk) disable iff (!rst_n)
        l_vld |=> l_out_vld);

    // R5: the level moves only on a tick
    assert_lvl_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_tick |=> $stable(mute_lvl));

    // R6: the level never jumps by more than one tick's share
    assert_lvl_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ms_tick |=> ((mute_lvl >= $past(mute_lvl) ? mute_lvl - $past(mute_lvl)
                                                  : $past(mute_lvl) - mute_lvl) <= LW'(MAXSTEP)));

    // R9: the silence flag rises only on a tick
    assert_flag_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(silence) |-> $past(ms_tick));

    // R10: a nonzero sample lowers the flag next clock
    assert_nonzero_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ((l_vld && l_smp != '0) || (r_vld && r_smp != '0)) |=> !silence);
endmodule

bind out_level_ctrl oc_level_chk #(.DW(DW), .AW(AW), .STEPS(STEPS), .RAMP_MS(RAMP_MS)) u_chk (
    .clk(clk), .rst_n(rst_n), .l_vld(l_vld), .l_smp(l_smp), .r_vld(r_vld), .r_smp(r_smp),
    .att_code(att_code), .ms_tick(ms_tick), .l_out(l_out), .l_out_vld(l_out_vld),
    .silence(silence), .mute_lvl(mute_lvl)
);

// File: tb/tb_out_level_ctrl.sv
module tb_out_level_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_vld = 0, r_vld = 0, mute_req = 0, ms_tick = 0;
    logic signed [15:0] l_smp = 0, r_smp = 0;
    logic [6:0] att_code = 7'd127;
    logic signed [15:0] l_out, r_out;
    logic l_out_vld, r_out_vld, silence;
    int n_run = 0, n_fail = 0;

    always #2 clk = ~clk;

    out_level_ctrl dut (
        .clk(clk), .rst_n(rst_n), .l_vld(l_vld), .l_smp(l_smp), .r_vld(r_vld), .r_smp(r_smp),
        .att_code(att_code), .mute_req(mute_req), .ms_tick(ms_tick),
        .l_out(l_out), .l_out_vld(l_out_vld), .r_out(r_out), .r_out_vld(r_out_vld),
        .silence(silence)
    );

    localparam int NV = 12;
    localparam logic signed [15:0] V_IN  [NV] = '{16'sd1000, -16'sd1000, 16'sd12345, 16'sd32767,
        -16'sd32768, 16'sd32767, -16'sd32768, 16'sd100, -16'sd100, 16'sd127, 16'sd32767, -16'sd32768};
    localparam logic [6:0]         V_CODE[NV] = '{7'd127, 7'd127, 7'd0, 7'd122,
        7'd122, 7'd1, 7'd1, 7'd126, 7'd126, 7'd64, 7'd127, 7'd127};
    localparam logic signed [15:0] V_EXP [NV] = '{16'sd1000, -16'sd1000, 16'sd0, 16'sd31476,
        -16'sd31477, 16'sd258, -16'sd258, 16'sd99, -16'sd99, 16'sd64, 16'sd32767, -16'sd32768};
    localparam string V_REQ[NV] = '{"R1", "R1", "R2", "R3", "R3", "R3", "R3", "R3", "R3", "R3", "R1", "R1"};

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic send(input logic signed [15:0] ls, input logic signed [15:0] rs);
        @(negedge clk);
        l_vld = 1; r_vld = 1; l_smp = ls; r_smp = rs;
        @(negedge clk);
        l_vld = 0; r_vld = 0;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); ms_tick = 1;
            @(negedge clk); ms_tick = 0;
        end
    endtask

    // Full-scale probe: expected output at a given mute level
    function automatic int at_lvl(input int lvl);
        return (32767 * lvl) / 64;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk("R11 l_out", l_out, 0);
        chk("R11 r_out", r_out, 0);
        chk("R11 strobe", {l_out_vld, r_out_vld}, 0);
        chk("R11 silence", silence, 0);
        send(16'sd32767, 16'sd32767);
        chk("R11 full level", l_out, 32767);

        // Vector table: R1 R2 R3
        for (int i = 0; i < NV; i++) begin
            att_code = V_CODE[i];
            send(V_IN[i], V_IN[i]);
            chk({V_REQ[i], " left"}, l_out, V_EXP[i]);
            chk({V_REQ[i], " right"}, r_out, V_EXP[i]);
            chk("R4 strobe", l_out_vld & r_out_vld, 1);
        end

        // R4: hold without strobe
        repeat (3) @(negedge clk);
        chk("R4 strobe low", l_out_vld | r_out_vld, 0);
        chk("R4 hold", l_out, -32768);

        // R5: mute ramp down
        att_code = 7'd127;
        @(negedge clk); mute_req = 1;
        repeat (2) @(negedge clk);
        tick(10);
        send(16'sd32767, 16'sd32767);
        chk("R5 t10", l_out, at_lvl(32));
        tick(9);
        send(16'sd32767, 16'sd32767);
        chk("R5 t19", l_out, at_lvl(4));
        tick(1);
        send(16'sd32767, 16'sd32767);
        chk("R5 t20", l_out, 0);

        // R6: ramp up from silence
        @(negedge clk); mute_req = 0;
        repeat (2) @(negedge clk);
        tick(7);
        send(16'sd32767, 16'sd32767);
        chk("R6 t7", l_out, at_lvl((64 * 7) / 20));
        tick(13);
        send(16'sd32767, 16'sd32767);
        chk("R6 t20", l_out, 32767);

        // R7: withdrawing the request mid-ramp does not stop it
        @(negedge clk); mute_req = 1;
        repeat (2) @(negedge clk);
        tick(5);
        @(negedge clk); mute_req = 0;
        tick(10);
        send(16'sd32767, 16'sd32767);
        chk("R7 t15", l_out, at_lvl(64 - (64 * 15) / 20));
        tick(5);
        send(16'sd32767, 16'sd32767);
        chk("R7 reached silence", l_out, 0);
        // R8: stale request re-taken, ramp up starts by itself
        repeat (2) @(negedge clk);
        tick(10);
        send(16'sd32767, 16'sd32767);
        chk("R8 auto ramp up", l_out, at_lvl(32));
        tick(10);
        send(16'sd32767, 16'sd32767);
        chk("R8 back to full", l_out, 32767);

        // R9: silence run
        send(16'sd0, 16'sd0);
        tick(349);
        chk("R9 at 349", silence, 0);
        tick(1);
        chk("R9 at 350", silence, 1);

        // R10: nonzero left clears and restarts
        send(16'sd5, 16'sd0);
        chk("R10 left clears", silence, 0);
        send(16'sd0, 16'sd0);
        tick(349);
        chk("R10 restart 349", silence, 0);
        tick(1);
        chk("R10 restart 350", silence, 1);
        @(negedge clk); r_vld = 1; r_smp = -16'sd1;
        @(negedge clk); r_vld = 0;
        chk("R10 right clears", silence, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule